// File: doc/BRIEF.md
# Bit-Addressable I/O Port

This peripheral sits on an 8-bit processor bus and gives every external input and every output latch an address of its own. Reading an address in the input window returns one synchronised external condition on data bit 7. A shift-left or rotate-left on that address therefore moves the condition into the processor carry flag, and no register is disturbed. Writing an address in the output window loads one latch from data bit 0. A shift-left on an output address therefore clears that latch, because the shifted value always has 0 in bit 0.

The two windows are each eight addresses wide, aligned, and placed at separate parameterised bases. Address bits 2..0 select the bit. A read-modify-write instruction may write twice to the same address, first the unmodified value and then the modified one. Each write overwrites the latch, so the last write sets the final state. External inputs cross into the clock domain through a two-flop synchroniser.

Top module: `bitport`

## Requirements
- R1: With cs high and addr in the input window (addr[15:3] equal to IN_BASE[15:3]), rdata[7] is the synchronised input selected by addr[2:0] and rdata[6:0] is 0.
- R2: A change on pins_in shows on an input read only after two rising clock edges. A read in the cycle of the change, or one edge later, still returns the old value.
- R3: On a rising edge with cs and we high and addr in the output window (addr[15:3] equal to OUT_BASE[15:3]), latch addr[2:0] takes wdata[0]. wdata[7:1] is ignored and all other latches keep their values.
- R4: A write whose bit 0 is 0, such as 0x80 written back by a shift-left, clears the addressed latch.
- R5: A write with cs low, with we low, or with an address outside the output window changes no latch.
- R6: With cs high and addr in the output window, rdata is {latch[addr[2:0]], 7'b0}. During a write cycle it shows the value from before the write.
- R7: Two consecutive writes to the same output address leave the latch at the value of the second write.
- R8: A synchronous reset (rst high at a rising edge) clears all latches and the synchroniser, so pins_out is 0 after the edge.
- R9: With cs low, or with an address in neither window, rdata is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select, active high |
| we | input | 1 | Write strobe, active high |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Write data; only bit 0 is used |
| rdata | output | 8 | Read data, combinational from addr and state |
| pins_in | input | 8 | Asynchronous external conditions |
| pins_out | output | 8 | Output latch bank |

## Verification
A read-modify-write cycle can read and write the same output latch at once. The bench drives cs, we and an output address together and checks that rdata still shows the old latch value in that cycle, while pins_out changes only after the edge. The bench also issues back-to-back writes to one address and changes an input while that input is being read. It then judges each cycle against a model that applies writes and synchroniser stages one edge late.

// File: rtl/bitport.sv
module bitport #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NBIT = 8,
  parameter logic [ADDR_W-1:0] IN_BASE = 16'hC000,
  parameter logic [ADDR_W-1:0] OUT_BASE = 16'hC008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [NBIT-1:0]   pins_in,
  output logic [NBIT-1:0]   pins_out
);
  localparam int unsigned SEL_W = $clog2(NBIT);

  logic [NBIT-1:0] meta_q, sync_q, lat_q;
  logic [SEL_W-1:0] sel;
  logic in_hit, out_hit, unused_wdata;

  assign sel     = addr[SEL_W-1:0];
  assign in_hit  = cs && (addr[ADDR_W-1:SEL_W] == IN_BASE[ADDR_W-1:SEL_W]);
  assign out_hit = cs && (addr[ADDR_W-1:SEL_W] == OUT_BASE[ADDR_W-1:SEL_W]);
  assign unused_wdata = ^wdata[7:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pins_in;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      lat_q <= '0;
    else if (out_hit && we)
      lat_q[sel] <= wdata[0];
  end

  always_comb begin
    rdata = 8'h00;
    if (in_hit)
      rdata[7] = sync_q[sel];
    else if (out_hit)
      rdata[7] = lat_q[sel];
  end

  assign pins_out = lat_q;
endmodule

// File: rtl/bitport_chk.sv
module bitport_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NBIT = 8,
  parameter logic [ADDR_W-1:0] IN_BASE = 16'hC000,
  parameter logic [ADDR_W-1:0] OUT_BASE = 16'hC008
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic [NBIT-1:0]   pins_in,
  input logic [NBIT-1:0]   pins_out
);
  localparam int unsigned SEL_W = $clog2(NBIT);
  logic [SEL_W-1:0] c_sel;
  logic c_in, c_out, c_wr, c_unused;
  assign c_sel = addr[SEL_W-1:0];
  assign c_in  = cs && (addr[ADDR_W-1:SEL_W] == IN_BASE[ADDR_W-1:SEL_W]);
  assign c_out = cs && (addr[ADDR_W-1:SEL_W] == OUT_BASE[ADDR_W-1:SEL_W]);
  assign c_wr  = c_out && we;
  assign c_unused = ^pins_in;

  p_low_zero_r1: assert property (@(posedge clk) disable iff (rst)
    c_in |-> rdata[6:0] == 7'd0);
  p_write_bit_r3: assert property (@(posedge clk) disable iff (rst)
    c_wr |=> pins_out[$past(c_sel)] == $past(wdata[0]));
  p_single_bit_r3: assert property (@(posedge clk) disable iff (rst)
    c_wr |=> $countones(pins_out ^ $past(pins_out)) <= 1);
  p_no_write_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !c_wr |=> $stable(pins_out));
  p_out_read_r6: assert property (@(posedge clk) disable iff (rst)
    c_out |-> rdata == {pins_out[c_sel], 7'd0});
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> pins_out == '0);
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (!c_in && !c_out) |-> rdata == 8'h00);
endmodule

bind bitport bitport_chk #(
  .ADDR_W(ADDR_W), .NBIT(NBIT), .IN_BASE(IN_BASE), .OUT_BASE(OUT_BASE)
) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pins_in(pins_in), .pins_out(pins_out)
);

// File: tb/bitport_tb.sv
module bitport_tb;
  localparam logic [15:0] INB = 16'hC000;
  localparam logic [15:0] OUTB = 16'hC008;

  logic clk = 0, rst = 1, cs = 0, we = 0;
  logic [15:0] addr = 16'h0;
  logic [7:0] wdata = 8'h0, rdata, pins_in = 8'h0, pins_out;

  typedef struct { logic [7:0] rd; logic [7:0] po; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_lat = 0, m_s1 = 0, m_s2 = 0;

  bitport u_dut (.clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pins_in(pins_in), .pins_out(pins_out));

  always #5 clk = ~clk;

  task automatic step(input logic r, input logic c, input logic w,
                      input logic [15:0] a, input logic [7:0] d,
                      input logic [7:0] p, input string tag);
    item_t it;
    @(posedge clk);
    if (rst) begin m_lat = 0; m_s1 = 0; m_s2 = 0; end
    else begin
      if (cs && we && addr[15:3] == OUTB[15:3]) m_lat[addr[2:0]] = wdata[0];
      m_s2 = m_s1; m_s1 = pins_in;
    end
    #2;
    rst = r; cs = c; we = w; addr = a; wdata = d; pins_in = p;
    it.rd = 8'h00;
    if (c && a[15:3] == INB[15:3]) it.rd = {m_s2[a[2:0]], 7'b0};
    else if (c && a[15:3] == OUTB[15:3]) it.rd = {m_lat[a[2:0]], 7'b0};
    it.po = m_lat;
    it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (rdata !== it.rd || pins_out !== it.po) begin
          errors++;
          $display("FAIL %s rdata=%h pins_out=%h expected rdata=%h pins_out=%h",
                   it.tag, rdata, pins_out, it.rd, it.po);
        end
      end
    end
  end

  initial begin : watchdog
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog rdata=%h expected completion", rdata);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] p;
    p = 8'hA5;
    step(1, 0, 0, 16'h0, 8'h0, p, "R8 reset");
    step(1, 0, 0, 16'h0, 8'h0, p, "R8 reset");
    step(0, 1, 0, INB, 8'h0, p, "R2 first edge old value");
    step(0, 1, 0, INB, 8'h0, p, "R2 second edge");
    step(0, 0, 0, INB, 8'h0, p, "R9 cs low");
    for (int i = 0; i < 8; i++)
      step(0, 1, 0, INB + 16'(i), 8'h0, p, "R1 input read");
    p = 8'h5A;
    step(0, 1, 0, INB + 16'd1, 8'h0, p, "R2 change cycle");
    step(0, 1, 0, INB + 16'd1, 8'h0, p, "R2 one edge");
    step(0, 1, 0, INB + 16'd1, 8'h0, p, "R2 two edges");
    step(0, 1, 0, INB + 16'd1, 8'h0, p, "R1 settled");
    for (int i = 0; i < 8; i++)
      step(0, 1, 1, OUTB + 16'(i), (i % 2 == 0) ? 8'hFF : 8'hFE, p, "R3 write bit0");
    step(0, 1, 1, OUTB + 16'd3, 8'h01, p, "R3 wdata high bits ignored");
    for (int i = 0; i < 8; i++)
      step(0, 1, 0, OUTB + 16'(i), 8'h0, p, "R6 latch readback");
    step(0, 1, 1, OUTB + 16'd2, 8'h80, p, "R4 shift-left clear");
    step(0, 1, 0, OUTB + 16'd2, 8'h0, p, "R4 cleared");
    step(0, 0, 1, OUTB + 16'd5, 8'h01, p, "R5 cs low");
    step(0, 1, 0, OUTB + 16'd5, 8'h01, p, "R5 we low");
    step(0, 1, 1, INB + 16'd5, 8'h01, p, "R5 input window write");
    step(0, 1, 1, 16'h1235, 8'h01, p, "R5 outside write");
    step(0, 1, 0, OUTB + 16'd5, 8'h0, p, "R5 latch unchanged");
    step(0, 1, 1, OUTB + 16'd6, 8'hC1, p, "R7 first write");
    step(0, 1, 1, OUTB + 16'd6, 8'h82, p, "R7 second write, R6 old value");
    step(0, 1, 0, OUTB + 16'd6, 8'h0, p, "R7 last write wins");
    step(0, 1, 1, OUTB + 16'd7, 8'h00, p, "R7 first write");
    step(0, 1, 1, OUTB + 16'd7, 8'h01, p, "R7 second write");
    step(0, 1, 0, OUTB + 16'd7, 8'h0, p, "R7 last write wins");
    step(0, 1, 0, 16'hC010, 8'h0, p, "R9 outside read");
    step(0, 1, 0, 16'h4000, 8'h0, p, "R9 outside read");
    step(1, 1, 1, OUTB + 16'd1, 8'h01, p, "R8 reset with write");
    step(0, 1, 0, OUTB + 16'd1, 8'h0, p, "R8 latch cleared");
    step(0, 1, 0, INB + 16'd1, 8'h0, p, "R8 synchroniser cleared");
    step(0, 0, 0, 16'h0, 8'h0, p, "R9 idle");
    wait (q.size() == 0);
    @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule